// File: doc/BRIEF.md
# Edge-Cleared Modem Interrupt Status

This block holds a single modem-line interrupt status bit for a serial port. A change of level on the clear-to-send input is synchronised into the UART clock domain and compared with its previous synchronised value. Any such change, in either direction, sets the status. Software acknowledges the status through a write-only clear bit, which loads a hidden clear latch.

The clear is not caused by the write itself. The status is cleared only in the cycle after the hidden latch goes from 0 to 1. The latch drops back to 0 by itself only while the status is 0. A set event overrides a clear that lands in the same cycle. When that happens, the latch stays at 1 and a further write of 1 achieves nothing. Software re-arms the latch by writing 0 and then writing 1. A mask bit gates the status onto the masked output. The mask does not affect setting or clearing.

Writes arrive already in the UART clock domain as a strobe and one data bit. There is one strobe for the clear bit and one for the mask bit.

Top module: `mdm_irq_status`

## Requirements
- R1: While reset is asserted, raw_stat and masked_stat are 0 and the mask bit is 0.
- R2: A rising change of cts_in first sampled at clock edge j makes raw_stat read 1 after edge j+2 and not earlier (SYNC_STAGES=2).
- R3: A falling change of cts_in sets raw_stat with the same latency as a rising change.
- R4: The cts_in level sampled at the first clock edge after reset release is the baseline. A cts_in held high through reset and afterwards never sets raw_stat.
- R5: Writing 1 (clr_we=1, wr_bit=1) while the clear latch is 0 loads 1 into the latch at write edge w. raw_stat then reads 0 from edge w+1, provided no set event coincides.
- R6: While raw_stat is 0 and no clear write occurs, the clear latch returns to 0. After a completed clear and a later new set, a single write of 1 clears the status again.
- R7: When a set event and a clear take effect at the same edge, raw_stat stays 1.
- R8: After a clear has been lost to a set, the latch holds 1. Further writes of 1 leave raw_stat at 1.
- R9: Writing 0 and then 1 to the clear bit, on back-to-back cycles or later, re-arms the latch. raw_stat reads 0 one edge after the write of 1.
- R10: masked_stat equals raw_stat AND the mask bit. The mask bit is written with mask_we=1 and taken from wr_bit. The mask changes neither the setting nor the clearing of raw_stat.
- R11: A write of 0 to the clear bit never changes raw_stat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | UART clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cts_in | input | 1 | Asynchronous clear-to-send line |
| clr_we | input | 1 | Write strobe for the clear bit |
| mask_we | input | 1 | Write strobe for the mask bit |
| wr_bit | input | 1 | Write data bit shared by both strobes |
| raw_stat | output | 1 | Unmasked interrupt status |
| masked_stat | output | 1 | Status gated by the mask bit |

## Verification
The stimulus covers several patterns:
- Rising and falling changes of the line, which tell an edge detector apart from a level detector.
- A line held high across reset, which exposes a false edge after reset.
- A plain write of 1 after a write of 0, which separates a transition-triggered clear from a level-triggered one.
- A change of the line timed so its set lands on the same edge as the clear pulse, which shows which of the two wins.
- A repeated write of 1 after that collision, followed by the 0-then-1 recovery sequence, which confirms that the latch sticks and can be re-armed.
- Mask writes in both directions around a set and a clear, which show that the mask gates only the output.

A behavioural model built from a sample queue predicts both outputs on every clock.

// File: rtl/mdm_irq_pkg.sv
package mdm_irq_pkg;

  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Events that compete for the status bit in one cycle
  typedef struct packed {
    logic set_evt;
    logic clr_pulse;
  } stat_evt_t;

endpackage

// File: rtl/mdm_cts_edge.sv
module mdm_cts_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_in,
  output logic edge_o
);

  localparam int unsigned WARM_MAX = SYNC_STAGES + 1;
  localparam int unsigned WARM_W   = $clog2(WARM_MAX + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic [WARM_W-1:0]      warm_q, warm_d;
  logic                   warm_en;

  // synchroniser chain
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= cts_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= sync_q[SYNC_STAGES-1];
  end

  // warm-up counter: edges are ignored until history holds a real sample
  always_comb begin
    warm_en = (warm_q != WARM_W'(WARM_MAX));
    warm_d  = warm_q + WARM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       warm_q <= '0;
    else if (warm_en) warm_q <= warm_d;
  end

  assign edge_o = !warm_en && (sync_q[SYNC_STAGES-1] ^ hist_q);

endmodule

// File: rtl/mdm_clr_latch.sv
module mdm_clr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wr_bit,
  input  logic stat_zero,
  output logic latch_o,
  output logic pulse_o
);

  logic latch_q, latch_d;
  logic prev_q;

  // a write has priority; otherwise the latch drops while status is 0
  always_comb begin
    latch_d = latch_q;
    if (we)             latch_d = wr_bit;
    else if (stat_zero) latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      prev_q  <= latch_q;
    end
  end

  assign latch_o = latch_q;
  assign pulse_o = latch_q & ~prev_q;

endmodule

// File: rtl/mdm_stat_reg.sv
module mdm_stat_reg
  import mdm_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  stat_evt_t evt,
  output logic      stat_o
);

  logic stat_q, stat_d;

  // set takes priority over clear
  always_comb begin
    stat_d = stat_q;
    if (evt.set_evt)        stat_d = 1'b1;
    else if (evt.clr_pulse) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/mdm_irq_status.sv
module mdm_irq_status
  import mdm_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_in,
  input  logic clr_we,
  input  logic mask_we,
  input  logic wr_bit,
  output logic raw_stat,
  output logic masked_stat
);

  logic      set_evt;
  logic      clr_pulse;
  logic      clr_latch;
  logic      mask_q;
  stat_evt_t evt;

  mdm_cts_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .cts_in (cts_in),
    .edge_o (set_evt)
  );

  mdm_clr_latch u_clr (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (clr_we),
    .wr_bit    (wr_bit),
    .stat_zero (~raw_stat),
    .latch_o   (clr_latch),
    .pulse_o   (clr_pulse)
  );

  assign evt = '{set_evt: set_evt, clr_pulse: clr_pulse};

  mdm_stat_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .stat_o (raw_stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 1'b0;
    else if (mask_we) mask_q <= wr_bit;
  end

  assign masked_stat = raw_stat & mask_q;

endmodule

// File: rtl/mdm_irq_status_chk.sv
module mdm_irq_status_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_we,
  input logic raw_stat,
  input logic masked_stat,
  input logic set_evt,
  input logic clr_pulse,
  input logic clr_latch
);

  // R2
  set_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> raw_stat);

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !set_evt) |=> !raw_stat);

  // R5
  fall_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(raw_stat) |-> $past(clr_pulse));

  // R7
  rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_stat) |-> $past(set_evt));

  // R6
  latch_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!raw_stat && !clr_we) |=> !clr_latch);

  // R10
  mask_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    masked_stat |-> raw_stat);

endmodule

bind mdm_irq_status mdm_irq_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_we      (clr_we),
  .raw_stat    (raw_stat),
  .masked_stat (masked_stat),
  .set_evt     (set_evt),
  .clr_pulse   (clr_pulse),
  .clr_latch   (clr_latch)
);

// File: tb/sim_mdm_irq_status.sv
module sim_mdm_irq_status;

  localparam int N = 2;

  logic clk;
  logic rst_n;
  logic cts_in, clr_we, mask_we, wr_bit;
  logic raw_stat, masked_stat;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  mdm_irq_status #(.SYNC_STAGES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .clr_we(clr_we),
    .mask_we(mask_we), .wr_bit(wr_bit), .raw_stat(raw_stat),
    .masked_stat(masked_stat)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference model
  bit m_stat, m_latch, m_prev, m_mask;
  int k;
  bit samp[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_latch = 0; m_prev = 0; m_mask = 0; k = 0;
      samp.delete();
    end else begin
      bit set, pulse, nstat, nlatch;
      k++;
      samp.push_back(cts_in);
      if (samp.size() > N + 2) void'(samp.pop_front());
      set = 0;
      if (k >= N + 2) set = (samp[samp.size()-1-N] != samp[samp.size()-2-N]);
      pulse  = m_latch && !m_prev;
      nstat  = set ? 1'b1 : (pulse ? 1'b0 : m_stat);
      nlatch = clr_we ? wr_bit : (!m_stat ? 1'b0 : m_latch);
      m_prev  = m_latch;
      m_latch = nlatch;
      m_stat  = nstat;
      if (mask_we) m_mask = wr_bit;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk("REF raw", raw_stat, m_stat);
    chk("REF masked", masked_stat, m_stat & m_mask);
  endtask

  task automatic wr_clr(input logic b);
    clr_we = 1'b1; wr_bit = b;
    tick();
    clr_we = 1'b0; wr_bit = 1'b0;
  endtask

  task automatic wr_mask(input logic b);
    mask_we = 1'b1; wr_bit = b;
    tick();
    mask_we = 1'b0; wr_bit = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; cts_in = 1'b1; clr_we = 1'b0; mask_we = 1'b0; wr_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 raw in reset", raw_stat, 1'b0);
    chk("R1 masked in reset", masked_stat, 1'b0);
    rst_n = 1'b1;
    repeat (6) tick();
    chk("R4 no false edge", raw_stat, 1'b0);

    // falling change
    cts_in = 1'b0;
    tick(); tick();
    chk("R3 not yet set", raw_stat, 1'b0);
    tick();
    chk("R3 falling sets", raw_stat, 1'b1);

    wr_clr(1'b0); tick(); tick();
    chk("R11 zero write no effect", raw_stat, 1'b1);

    wr_clr(1'b1);
    chk("R5 not yet cleared", raw_stat, 1'b1);
    tick();
    chk("R5 cleared", raw_stat, 1'b0);
    tick(); tick();

    // rising change
    cts_in = 1'b1;
    tick(); tick();
    chk("R2 not yet set", raw_stat, 1'b0);
    tick();
    chk("R2 rising sets", raw_stat, 1'b1);

    wr_clr(1'b1); tick();
    chk("R6 latch rearmed by itself", raw_stat, 1'b0);
    tick(); tick();

    cts_in = 1'b0;
    repeat (3) tick();
    chk("R3 set again", raw_stat, 1'b1);

    // collision: set and clear at the same edge
    cts_in = 1'b1;
    tick();
    wr_clr(1'b1);
    tick();
    chk("R7 set wins", raw_stat, 1'b1);

    wr_clr(1'b1); tick(); tick();
    chk("R8 stuck latch", raw_stat, 1'b1);

    wr_clr(1'b0); wr_clr(1'b1); tick();
    chk("R9 recovery clears", raw_stat, 1'b0);
    tick(); tick();

    // mask
    wr_mask(1'b1);
    chk("R10 masked idle", masked_stat, 1'b0);
    cts_in = 1'b0;
    repeat (3) tick();
    chk("R10 raw set", raw_stat, 1'b1);
    chk("R10 masked set", masked_stat, 1'b1);
    wr_mask(1'b0);
    chk("R10 mask off", masked_stat, 1'b0);
    chk("R10 raw kept", raw_stat, 1'b1);
    wr_clr(1'b1); tick();
    chk("R10 clear with mask off", raw_stat, 1'b0);

    summary();
  end

endmodule